// File: doc/BRIEF.md
# Handshaked Word Bus Cycle Master

This block runs the master side of a 16-bit asynchronous memory bus. Local logic hands it one transfer at a time: a read or write, a word address, a 16-bit write value and two byte-lane enables. The block then runs a fixed sequence on the bus. It first presents the address and direction. One clock later it lowers the address strobe. One clock after that it lowers the byte strobes for the lanes that are enabled, and it drives write data when the transfer is a write. The strobes stay low until the addressed device pulls the acknowledge line low.

The bus carries no address bit 0, so the address lines name a 16-bit word. Bits 15:8 form the even (upper) byte and bits 7:0 form the odd (lower) byte. Each byte has its own strobe.

The acknowledge line comes in through a two-flop synchronizer. After the acknowledge is seen, the block latches read data and raises the address strobe and both byte strobes on the same clock. It then waits for the device to release the acknowledge before it reports completion. A programmable limit on wait clocks ends a transfer that no device answers, and that transfer is reported with an error flag.

The request side is a valid/ready channel. `req_ready` is high only while the controller is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While the controller is busy, `req_valid` has no effect, and the requester must hold its request until `req_ready` returns. The response is a one-clock `rsp_valid` pulse with no back-pressure, so the consumer must take it in the clock it appears.

Top module: `async_bus_master`

## Requirements
- R1: During and after reset, `bus_as_n`, `bus_uds_n` and `bus_lds_n` are high, `bus_doe` and `rsp_valid` are low, `req_ready` is high and `busy` is low.
- R2: For each accepted request, `bus_addr` equals `req_addr` and `bus_rw` is set for the direction (1 = read, 0 = write). Both are valid at least one clock before `bus_as_n` falls, and neither changes while `bus_as_n` stays low. The byte strobes fall only after `bus_as_n` is already low.
- R3: Byte enable bit 1 selects the even byte on data bits 15:8 and lowers `bus_uds_n`. Byte enable bit 0 selects the odd byte on bits 7:0 and lowers `bus_lds_n`. A word transfer (enables 2'b11) lowers both strobes. A single-byte transfer lowers only its own strobe.
- R4: On a write, `bus_doe` is high and `bus_dout` equals the write value in every clock that the strobes are low. On a read, `bus_doe` stays low.
- R5: The strobes stay low until the acknowledge has passed two synchronizer flops. When `bus_ack_n` falls at a falling clock edge D clocks after the strobes were first seen low, the strobes are seen low for exactly D+3 falling edges.
- R6: A read returns, with `rsp_valid`, the word the device presented while it held the acknowledge low. `rsp_err` is 0 and `rsp_valid` lasts exactly one clock.
- R7: `bus_as_n` and both byte strobes are raised on the same clock. A byte strobe is never low while `bus_as_n` is high.
- R8: After the strobes rise, the block waits for the synchronized acknowledge to return high before `rsp_valid`. If the device releases its acknowledge H falling edges after `bus_as_n` is seen high, `rsp_valid` is seen H+3 falling edges after that rise. `busy` stays high and `req_ready` stays low from acceptance until the response.
- R9: If no acknowledge arrives, the strobes stay low for `timeout_limit`+1 clocks. The transfer then ends with `rsp_err` = 1. A device that answers within the limit gives `rsp_err` = 0.
- R10: A `req_valid` raised while `busy` is high starts no bus cycle and changes no data on the bus.
- R11: All AW address bits are carried to `bus_addr`, including the most significant one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write value |
| req_be | input | 2 | Byte enables: bit 1 even byte (15:8), bit 0 odd byte (7:0) |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data (0 for writes) |
| rsp_err | output | 1 | Transfer ended by timeout |
| busy | output | 1 | Bus cycle in progress |
| timeout_limit | input | TW | Wait-clock limit before error |
| bus_addr | output | AW | Word address lines |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper (even) byte strobe, active low |
| bus_lds_n | output | 1 | Lower (odd) byte strobe, active low |
| bus_dout | output | 16 | Write data toward the bus |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | 16 | Read data from the bus |
| bus_ack_n | input | 1 | Transfer acknowledge, active low, asynchronous |

## Verification
The bench runs word writes and reads, then single writes to the even byte and to the odd byte, and reads the word back. The read-back values show whether each enable reached the correct lane and the correct strobe. The acknowledge delay is swept over 0, 4 and 9 clocks, and the acknowledge hold after the strobes rise is stretched. These runs set the exact strobe-low length apart from a fixed-length cycle, and completion on acknowledge release apart from completion on strobe rise. A device that never answers exercises the timeout. A request offered while busy, followed by a read-back, shows that the request was dropped.

// File: rtl/async_bus_pkg.sv
package async_bus_pkg;
  localparam int BUS_DW = 16;
  localparam int LANES  = BUS_DW / 8;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_SETUP,
    CYC_ADDR,
    CYC_STRB,
    CYC_REL
  } cyc_state_e;

  typedef struct packed {
    logic             wr;
    logic [LANES-1:0] lanes;
  } cyc_ctrl_t;
endpackage

// File: rtl/async_bus_ack_sync.sv
module async_bus_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/async_bus_wait_timer.sv
module async_bus_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          count_en,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  assign expired = (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clear)                 cnt <= '0;
    else if (count_en && !expired)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/async_bus_cycle_fsm.sv
module async_bus_cycle_fsm
  import async_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ack_low,
  input  logic       expired,
  output cyc_state_e state,
  output logic       timer_clear,
  output logic       timer_en,
  output logic       capture,
  output logic       fail,
  output logic       done
);
  cyc_state_e nxt;

  always_comb begin
    nxt         = state;
    timer_clear = 1'b0;
    timer_en    = 1'b0;
    capture     = 1'b0;
    fail        = 1'b0;
    done        = 1'b0;
    case (state)
      CYC_IDLE:  if (start) nxt = CYC_SETUP;
      CYC_SETUP: nxt = CYC_ADDR;
      CYC_ADDR: begin
        nxt         = CYC_STRB;
        timer_clear = 1'b1;
      end
      CYC_STRB: begin
        if (ack_low) begin
          nxt         = CYC_REL;
          capture     = 1'b1;
          timer_clear = 1'b1;
        end else if (expired) begin
          nxt         = CYC_REL;
          fail        = 1'b1;
          timer_clear = 1'b1;
        end else begin
          timer_en = 1'b1;
        end
      end
      CYC_REL: begin
        if (!ack_low) begin
          nxt  = CYC_IDLE;
          done = 1'b1;
        end else if (expired) begin
          nxt  = CYC_IDLE;
          done = 1'b1;
          fail = 1'b1;
        end else begin
          timer_en = 1'b1;
        end
      end
      default: nxt = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= CYC_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/async_bus_drive.sv
module async_bus_drive
  import async_bus_pkg::*;
#(
  parameter int AW = 23
) (
  input  cyc_state_e        state,
  input  cyc_ctrl_t         ctrl,
  input  logic [AW-1:0]     addr_q,
  input  logic [BUS_DW-1:0] wdata_q,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_rw,
  output logic              bus_as_n,
  output logic              bus_uds_n,
  output logic              bus_lds_n,
  output logic [BUS_DW-1:0] bus_dout,
  output logic              bus_doe
);
  logic             in_cycle;
  logic             as_on;
  logic             stb_on;
  logic [LANES-1:0] lane_n;

  assign in_cycle = (state != CYC_IDLE);
  assign as_on    = (state == CYC_ADDR) || (state == CYC_STRB);
  assign stb_on   = (state == CYC_STRB);

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_n[g] = !(stb_on && ctrl.lanes[g]);
    end
  endgenerate

  assign bus_addr  = in_cycle ? addr_q : '0;
  assign bus_rw    = in_cycle ? !ctrl.wr : 1'b1;
  assign bus_as_n  = !as_on;
  assign bus_uds_n = lane_n[1];
  assign bus_lds_n = lane_n[0];
  assign bus_doe   = stb_on && ctrl.wr;
  assign bus_dout  = bus_doe ? wdata_q : '0;
endmodule

// File: rtl/async_bus_master.sv
module async_bus_master
  import async_bus_pkg::*;
#(
  parameter int AW          = 23,
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [BUS_DW-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [BUS_DW-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              busy,
  input  logic [TW-1:0]     timeout_limit,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_rw,
  output logic              bus_as_n,
  output logic              bus_uds_n,
  output logic              bus_lds_n,
  output logic [BUS_DW-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [BUS_DW-1:0] bus_din,
  input  logic              bus_ack_n
);
  cyc_state_e        state;
  cyc_ctrl_t         ctrl_q;
  logic [AW-1:0]     addr_q;
  logic [BUS_DW-1:0] wdata_q;
  logic [BUS_DW-1:0] rdata_q;
  logic              err_q;
  logic              ack_s;
  logic              start, timer_clear, timer_en, capture, fail, done, expired;

  assign req_ready = (state == CYC_IDLE);
  assign busy      = !req_ready;
  assign start     = req_valid && req_ready;

  async_bus_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(bus_ack_n), .sync_out(ack_s)
  );

  async_bus_wait_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(timer_clear), .count_en(timer_en),
    .limit(timeout_limit), .expired(expired)
  );

  async_bus_cycle_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .ack_low(!ack_s),
    .expired(expired), .state(state), .timer_clear(timer_clear),
    .timer_en(timer_en), .capture(capture), .fail(fail), .done(done)
  );

  async_bus_drive #(.AW(AW)) u_drive (
    .state(state), .ctrl(ctrl_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_as_n(bus_as_n),
    .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      ctrl_q  <= '{wr: req_write, lanes: req_be};
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (start) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (capture && !ctrl_q.wr) rdata_q <= bus_din;
      if (fail)                  err_q   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= done;
      if (done) begin
        rsp_rdata <= rdata_q;
        rsp_err   <= err_q || fail;
      end
    end
  end
endmodule

// File: rtl/async_bus_master_chk.sv
module async_bus_master_chk #(
  parameter int AW = 23
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rw,
  input logic          bus_as_n,
  input logic          bus_uds_n,
  input logic          bus_lds_n,
  input logic          bus_doe
);
  assert_strobe_inside_as_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_uds_n && bus_lds_n) |-> !bus_as_n);

  assert_joint_negate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_n) |-> (bus_uds_n && bus_lds_n));

  assert_addr_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as_n) |-> ($stable(bus_addr) && $stable(bus_rw) && bus_uds_n && bus_lds_n));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_as_n && $past(!bus_as_n)) |-> ($stable(bus_addr) && $stable(bus_rw)));

  assert_doe_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (!bus_rw && !(bus_uds_n && bus_lds_n)));

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_ready && bus_as_n));
endmodule

bind async_bus_master async_bus_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_as_n(bus_as_n),
  .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_doe(bus_doe)
);

// File: tb/async_bus_master_tb.sv
module async_bus_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 23;
  localparam int TW = 16;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic [TW-1:0] timeout_limit = 16'd200;
  logic req_ready, rsp_valid, rsp_err, busy;
  logic [15:0] rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic bus_rw, bus_as_n, bus_uds_n, bus_lds_n, bus_doe;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = 16'hDEAD;
  logic bus_ack_n = 1'b1;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_bus_master #(.AW(AW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .busy(busy), .timeout_limit(timeout_limit),
    .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_as_n(bus_as_n),
    .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_ack_n(bus_ack_n)
  );

  // device model, acts on falling edges
  logic [15:0] mem [16];
  bit dev_on = 1'b1;
  int ack_delay = 0, ack_hold = 0;
  int dcnt = 0, hcnt = 0;
  bit acked = 1'b0;
  int as_falls = 0;
  bit prev_as_mon = 1'b1;

  initial for (int i = 0; i < 16; i++) mem[i] = 16'h0000;

  always @(negedge clk) begin
    if (!bus_as_n && prev_as_mon) as_falls++;
    prev_as_mon = bus_as_n;
    if (!bus_uds_n || !bus_lds_n) begin
      if (dev_on && !acked) begin
        if (dcnt >= ack_delay) begin
          if (!bus_uds_n && !bus_rw) mem[bus_addr[3:0]][15:8] = bus_dout[15:8];
          if (!bus_lds_n && !bus_rw) mem[bus_addr[3:0]][7:0]  = bus_dout[7:0];
          bus_din   = mem[bus_addr[3:0]];
          bus_ack_n = 1'b0;
          acked     = 1'b1;
          hcnt      = 0;
        end else dcnt++;
      end
    end else if (acked) begin
      if (hcnt >= ack_hold) begin
        bus_ack_n = 1'b1;
        bus_din   = 16'hDEAD;
        acked     = 1'b0;
        dcnt      = 0;
      end else hcnt++;
    end else dcnt = 0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // observations of the last transfer
  logic [15:0] o_rdata;
  bit o_err, o_seq_ok, o_dout_ok, o_busy_ok, o_uds, o_lds;
  int o_strb, o_gap;

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [15:0] wd,
                      input logic [1:0] be);
    bit prev_as = 1'b1;
    bit rose = 1'b0;
    int guard = 0;
    o_seq_ok = 1; o_dout_ok = 1; o_busy_ok = 1; o_uds = 0; o_lds = 0;
    o_strb = 0; o_gap = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (rsp_valid) break;
      if (!busy) o_busy_ok = 0;
      if (!bus_as_n && prev_as) begin
        if (!(bus_uds_n && bus_lds_n) || bus_addr !== a || bus_rw !== !wr) o_seq_ok = 0;
      end
      if ((!bus_uds_n || !bus_lds_n) && prev_as) o_seq_ok = 0;
      if (!bus_uds_n || !bus_lds_n) begin
        o_strb++;
        if (!bus_uds_n) o_uds = 1;
        if (!bus_lds_n) o_lds = 1;
        if (wr && (!bus_doe || bus_dout !== wd)) o_dout_ok = 0;
        if (!wr && bus_doe) o_dout_ok = 0;
      end
      if (bus_as_n && !prev_as) rose = 1;
      else if (rose) o_gap++;
      prev_as = bus_as_n;
      @(negedge clk);
      guard++;
      if (guard > 5000) break;
    end
    if (rose) o_gap++;
    o_rdata = rsp_rdata; o_err = rsp_err;
  endtask

  task automatic t_reset();
    check(bus_as_n && bus_uds_n && bus_lds_n, "R1", "strobes idle",
          {bus_as_n, bus_uds_n, bus_lds_n}, 3'b111);
    check(req_ready && !busy && !rsp_valid && !bus_doe, "R1", "ready/busy/rsp/doe",
          {req_ready, busy, rsp_valid, bus_doe}, 4'b1000);
  endtask

  task automatic t_word();
    ack_delay = 1; ack_hold = 0;
    xfer(1, 23'd3, 16'hA5C3, 2'b11);
    check(o_seq_ok, "R2", "write address/AS/strobe order", o_seq_ok, 1);
    check(o_uds && o_lds, "R3", "word write both strobes", {o_uds, o_lds}, 2'b11);
    check(o_dout_ok, "R4", "write data driven with strobes", o_dout_ok, 1);
    check(!o_err, "R4", "write no error", o_err, 0);
    xfer(0, 23'd3, 16'h0, 2'b11);
    check(o_seq_ok, "R2", "read order and direction", o_seq_ok, 1);
    check(o_dout_ok, "R4", "read keeps doe low", o_dout_ok, 1);
    check(o_rdata == 16'hA5C3 && !o_err, "R6", "read word", o_rdata, 16'hA5C3);
  endtask

  task automatic t_bytes();
    ack_delay = 2;
    xfer(1, 23'd3, 16'h7E00, 2'b10);
    check(o_uds && !o_lds, "R3", "even byte uses upper strobe only", {o_uds, o_lds}, 2'b10);
    xfer(1, 23'd3, 16'h0011, 2'b01);
    check(!o_uds && o_lds, "R3", "odd byte uses lower strobe only", {o_uds, o_lds}, 2'b01);
    xfer(0, 23'd3, 16'h0, 2'b11);
    check(o_rdata == 16'h7E11, "R3", "byte lanes merged", o_rdata, 16'h7E11);
  endtask

  task automatic t_latency();
    int ds [3] = '{0, 4, 9};
    foreach (ds[k]) begin
      ack_delay = ds[k]; ack_hold = 0;
      mem[7] = 16'h1200 + 16'(k);
      xfer(0, 23'd7, 16'h0, 2'b11);
      check(o_strb == ds[k] + 3, "R5", "strobe-low length vs ack delay", o_strb, ds[k] + 3);
      check(o_rdata == 16'h1200 + 16'(k), "R6", "read with delayed ack", o_rdata,
            16'h1200 + 16'(k));
    end
  endtask

  task automatic t_release();
    ack_delay = 1; ack_hold = 5;
    xfer(1, 23'd9, 16'h5A5A, 2'b11);
    check(o_gap == 8, "R8", "response waits for ack release", o_gap, 8);
    check(o_busy_ok, "R8", "busy held during cycle", o_busy_ok, 1);
    check(req_ready, "R8", "ready after response", req_ready, 1);
    ack_hold = 0;
  endtask

  task automatic t_timeout();
    dev_on = 0; timeout_limit = 16'd6;
    xfer(0, 23'd4, 16'h0, 2'b11);
    check(o_err, "R9", "timeout error flag", o_err, 1);
    check(o_strb == 7, "R9", "strobes held limit+1 clocks", o_strb, 7);
    dev_on = 1; timeout_limit = 16'd20; ack_delay = 3;
    xfer(0, 23'd4, 16'h0, 2'b11);
    check(!o_err, "R9", "answer within limit no error", o_err, 0);
    timeout_limit = 16'd200;
  endtask

  task automatic t_ignore();
    int base;
    ack_delay = 1;
    xfer(1, 23'd2, 16'h1234, 2'b11);
    ack_delay = 8;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 23'd2; req_be = 2'b11;
    @(negedge clk);
    req_write = 1'b1; req_wdata = 16'hFFFF;
    for (int i = 0; i < 3; i++) @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    base = as_falls;
    for (int i = 0; i < 12; i++) @(negedge clk);
    check(as_falls == base, "R10", "no cycle from busy-time request", as_falls - base, 0);
    ack_delay = 1;
    xfer(0, 23'd2, 16'h0, 2'b11);
    check(o_rdata == 16'h1234, "R10", "memory untouched", o_rdata, 16'h1234);
  endtask

  task automatic t_high_addr();
    ack_delay = 0;
    xfer(1, 23'h7FFFF3, 16'hBEEF, 2'b11);
    check(o_seq_ok, "R11", "full-width address on bus", o_seq_ok, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    fork
      begin
        t_word();
        t_bytes();
        t_latency();
        t_release();
        t_timeout();
        t_ignore();
        t_high_addr();
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule